// File: doc/BRIEF.md
# Outstanding Line Miss Tracker

This block keeps track of cache lines that have missed and are being fetched from the next level of the hierarchy. A load miss, a prefetch or a store ownership request arrives on a single request port. If no live entry holds that line, the lowest-numbered free entry is taken. If a live entry already holds the line, the request is attached to that entry and gets back its index with a merged flag, so one line never occupies two entries. A requester that is told it merged parks its load on the returned index and waits for a wakeup that names it. Requests that hit in the cache are acknowledged and leave no trace. Store data never enters the tracker: for an ownership miss only the request is held here.

Each entry runs a four-state machine. ES_FREE moves to ES_PEND on *allocate*. ES_PEND moves to ES_WAIT on *issue*, when its one downstream request is taken. ES_WAIT moves to ES_FULL on *last beat*, when the fourth fill beat arrives. ES_FULL moves back to ES_FREE on *drain*, when the cache accepts the whole line. Each beat is also passed on to the requester one cycle after it arrives, before the line reaches the cache. The wakeup is broadcast in the same cycle the cache write is accepted. The request type held in an entry can only rise. If it rises after the downstream request has left, completion reports that the entry was upgraded.

Top module: `mfb_tracker`

## Requirements
- R1: A request with `req_hit` high is acknowledged (`req_ready`=1), produces no response, allocates nothing and changes no entry.
- R2: A miss to a line held by no live entry takes the lowest-numbered free entry. One cycle later `rsp_valid`=1, with `rsp_idx` set to that entry, `rsp_merged`=0 and `rsp_rid` equal to the request's id.
- R3: A miss to a line held by an entry in the pending or issued state takes no new entry. One cycle later it gets that entry's index with `rsp_merged`=1.
- R4: Request types are 0 prefetch, 1 demand load, 2 speculative ownership and 3 demand ownership. A merged request with a higher code replaces the entry's type, and a lower or equal code leaves it unchanged. `dn_type` carries the type the entry holds when it issues.
- R5: A type raise that lands in or after the cycle of the entry's downstream issue makes `wake_upg`=1 at completion, with `wake_type` equal to the final type. Otherwise `wake_upg`=0.
- R6: A miss is refused (`req_ready`=0) when its line is held by no entry and no entry is free. It is also refused when its line matches an entry whose complete line is waiting for the cache write. A refused request changes nothing.
- R7: Each entry sends exactly one downstream request. `dn_valid` is high while any entry is unissued and offers the oldest unissued entry by allocation order. The offer holds while `dn_ready` is low.
- R8: Fill beats carry an entry index and are accepted only by an issued entry that is still collecting beats. Beat k (k=0..3, in arrival order) lands in bits [128k+127:128k] of `cw_data`. Beats sent to any other entry are ignored.
- R9: Each accepted beat appears one cycle later on `fwd_valid`/`fwd_idx`/`fwd_beat`/`fwd_data`, with `fwd_beat` giving its position 0..3.
- R10: After its fourth beat, an entry offers its line on `cw_valid`, lowest index first. `wake_valid` with `wake_idx` rises in the cycle `cw_ready` accepts it, and the entry is free from the next cycle.
- R11: After reset every entry is free and `rsp_valid`, `dn_valid`, `cw_valid`, `wake_valid` and `fwd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_hit | input | 1 | Request hit in the cache; no tracking needed |
| req_line | input | 26 | Line address of the request |
| req_type | input | 2 | Request type code (R4) |
| req_rid | input | 6 | Requester id, echoed in the response |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Registered response to an accepted miss |
| rsp_rid | output | 6 | Requester id of the response |
| rsp_idx | output | 4 | Entry the request was given or attached to |
| rsp_merged | output | 1 | Request joined an existing entry |
| dn_valid | output | 1 | Downstream line request offered |
| dn_ready | input | 1 | Next level takes the downstream request |
| dn_idx | output | 4 | Entry index of the downstream request |
| dn_line | output | 26 | Line address of the downstream request |
| dn_type | output | 2 | Request type sent downstream |
| fill_valid | input | 1 | Fill beat present |
| fill_idx | input | 4 | Entry index the beat belongs to |
| fill_data | input | 128 | Beat payload |
| fwd_valid | output | 1 | Early forward of an accepted beat |
| fwd_idx | output | 4 | Entry of the forwarded beat |
| fwd_beat | output | 2 | Position of the forwarded beat in its line |
| fwd_data | output | 128 | Forwarded beat payload |
| cw_valid | output | 1 | Complete line offered to the cache |
| cw_ready | input | 1 | Cache accepts the line write |
| cw_idx | output | 4 | Entry being written |
| cw_line | output | 26 | Line address being written |
| cw_data | output | 512 | Whole line data |
| wake_valid | output | 1 | Wakeup broadcast |
| wake_idx | output | 4 | Entry whose waiters may retry |
| wake_type | output | 2 | Final request type of the completing entry |
| wake_upg | output | 1 | Type was raised after the downstream request left |

## Verification
The collision that matters most is a type-raising merge that lands in the same cycle as the entry's downstream issue. The issued request carries the old type, so the raise must still be marked as an upgrade. Random traffic over a small pool of lines, with `dn_ready` toggling at random, makes this happen often. A second collision is a drain in the same cycle as a new miss or a merge on the draining line; the directed part forces it with every entry busy. The bench keeps its own model of entry states, types and allocation order. It judges every response, issue, forward, write and wakeup (including `wake_upg`) against that model in every cycle.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
    typedef enum logic [1:0] {
        ES_FREE = 2'd0,
        ES_PEND = 2'd1,
        ES_WAIT = 2'd2,
        ES_FULL = 2'd3
    } ent_state_t;

    localparam logic [1:0] RT_PREFETCH = 2'd0;
    localparam logic [1:0] RT_LOAD     = 2'd1;
    localparam logic [1:0] RT_SPEC_OWN = 2'd2;
    localparam logic [1:0] RT_OWN      = 2'd3;
endpackage

// File: rtl/mfb_lowpick.sv
module mfb_lowpick #(
    parameter int N = 10,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic [N-1:0]  oh_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        oh_o  = '0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                oh_o    = '0;
                oh_o[i] = 1'b1;
                idx_o   = IW'(i);
            end
        end
        any_o = |vec_i;
    end
endmodule

// File: rtl/mfb_age.sv
module mfb_age #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_oh_i,
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] pick_oh_o
);
    // older_q[i][j] set: entry i was allocated before entry j
    logic [N-1:0] older_q [N];
    logic [N-1:0] blocked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older_q[i] <= '0;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (alloc_oh_i[k]) begin
                    older_q[k] <= '0;
                    for (int j = 0; j < N; j++) begin
                        if (j != k) older_q[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && cand_i[j] && older_q[j][i]) blocked[i] = 1'b1;
            end
        end
        pick_oh_o = cand_i & ~blocked;
    end

    AST_AGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_oh_o)); // R7
    AST_AGE_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (|cand_i) |-> (|pick_oh_o)); // R7
endmodule

// File: rtl/mfb_entry.sv
module mfb_entry
    import mfb_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int TYPE_W = 2,
    parameter int BEAT_W = 128,
    parameter int NBEATS = 4,
    localparam int CNT_W = $clog2(NBEATS),
    localparam int LINE_BITS = BEAT_W * NBEATS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_i,
    input  logic                 merge_i,
    input  logic                 issue_i,
    input  logic                 beat_i,
    input  logic                 drain_i,
    input  logic [LINE_W-1:0]    req_line_i,
    input  logic [TYPE_W-1:0]    req_type_i,
    input  logic [BEAT_W-1:0]    beat_data_i,
    output ent_state_t           state_o,
    output logic [LINE_W-1:0]    line_o,
    output logic [TYPE_W-1:0]    type_o,
    output logic                 upg_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [LINE_BITS-1:0] data_o
);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(NBEATS - 1);

    ent_state_t           state_q, state_d;
    logic [LINE_W-1:0]    line_q;
    logic [TYPE_W-1:0]    type_q;
    logic                 upg_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [LINE_BITS-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ES_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ES_FREE: if (alloc_i) state_d = ES_PEND;
            ES_PEND: if (issue_i) state_d = ES_WAIT;
            ES_WAIT: if (beat_i && cnt_q == LAST_BEAT) state_d = ES_FULL;
            ES_FULL: if (drain_i) state_d = ES_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            type_q <= '0;
            upg_q  <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            if (alloc_i) begin
                line_q <= req_line_i;
                type_q <= req_type_i;
                upg_q  <= 1'b0;
                cnt_q  <= '0;
            end
            if (merge_i && req_type_i > type_q) begin
                type_q <= req_type_i;
                if (state_q == ES_WAIT || issue_i) upg_q <= 1'b1;
            end
            if (beat_i) begin
                data_q[cnt_q*BEAT_W +: BEAT_W] <= beat_data_i;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign state_o = state_q;
    assign line_o  = line_q;
    assign type_o  = type_q;
    assign upg_o   = upg_q;
    assign cnt_o   = cnt_q;
    assign data_o  = data_q;

    AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> state_q == ES_FREE); // R2
    AST_MERGE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        merge_i |-> (state_q == ES_PEND || state_q == ES_WAIT)); // R3
    AST_ISSUE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> state_q == ES_PEND); // R7
    AST_TYPE_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ES_FREE) |=> (state_q == ES_FREE || type_q >= $past(type_q))); // R4
endmodule

// File: rtl/mfb_tracker.sv
module mfb_tracker
    import mfb_pkg::*;
#(
    parameter int NUM_ENT = 10,
    parameter int LINE_W  = 26,
    parameter int TYPE_W  = 2,
    parameter int RID_W   = 6,
    parameter int BEAT_W  = 128,
    parameter int NBEATS  = 4,
    localparam int IDX_W  = $clog2(NUM_ENT),
    localparam int CNT_W  = $clog2(NBEATS),
    localparam int LINE_BITS = BEAT_W * NBEATS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_hit,
    input  logic [LINE_W-1:0]    req_line,
    input  logic [TYPE_W-1:0]    req_type,
    input  logic [RID_W-1:0]     req_rid,
    output logic                 req_ready,
    output logic                 rsp_valid,
    output logic [RID_W-1:0]     rsp_rid,
    output logic [IDX_W-1:0]     rsp_idx,
    output logic                 rsp_merged,
    output logic                 dn_valid,
    input  logic                 dn_ready,
    output logic [IDX_W-1:0]     dn_idx,
    output logic [LINE_W-1:0]    dn_line,
    output logic [TYPE_W-1:0]    dn_type,
    input  logic                 fill_valid,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [BEAT_W-1:0]    fill_data,
    output logic                 fwd_valid,
    output logic [IDX_W-1:0]     fwd_idx,
    output logic [CNT_W-1:0]     fwd_beat,
    output logic [BEAT_W-1:0]    fwd_data,
    output logic                 cw_valid,
    input  logic                 cw_ready,
    output logic [IDX_W-1:0]     cw_idx,
    output logic [LINE_W-1:0]    cw_line,
    output logic [LINE_BITS-1:0] cw_data,
    output logic                 wake_valid,
    output logic [IDX_W-1:0]     wake_idx,
    output logic [TYPE_W-1:0]    wake_type,
    output logic                 wake_upg
);
    ent_state_t           st  [NUM_ENT];
    logic [LINE_W-1:0]    ln  [NUM_ENT];
    logic [TYPE_W-1:0]    ty  [NUM_ENT];
    logic                 upg [NUM_ENT];
    logic [CNT_W-1:0]     cnt [NUM_ENT];
    logic [LINE_BITS-1:0] dat [NUM_ENT];

    logic [NUM_ENT-1:0] match_vec, free_vec, pend_vec, full_vec;
    logic [NUM_ENT-1:0] alloc_oh, merge_oh, issue_oh, drain_oh, beat_oh;
    logic [NUM_ENT-1:0] free_oh, full_oh, pend_pick_oh;
    logic [IDX_W-1:0]   free_idx, full_idx, match_idx;
    logic               free_any, full_any, match_any, match_full, take;
    logic [CNT_W-1:0]   beat_cnt;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        assign match_vec[g] = (st[g] != ES_FREE) && (ln[g] == req_line);
        assign free_vec[g]  = (st[g] == ES_FREE);
        assign pend_vec[g]  = (st[g] == ES_PEND);
        assign full_vec[g]  = (st[g] == ES_FULL);
        assign beat_oh[g]   = fill_valid && (fill_idx == IDX_W'(g)) && (st[g] == ES_WAIT);

        mfb_entry #(
            .LINE_W(LINE_W), .TYPE_W(TYPE_W), .BEAT_W(BEAT_W), .NBEATS(NBEATS)
        ) u_ent (
            .clk(clk), .rst_n(rst_n),
            .alloc_i(alloc_oh[g]), .merge_i(merge_oh[g]), .issue_i(issue_oh[g]),
            .beat_i(beat_oh[g]), .drain_i(drain_oh[g]),
            .req_line_i(req_line), .req_type_i(req_type), .beat_data_i(fill_data),
            .state_o(st[g]), .line_o(ln[g]), .type_o(ty[g]), .upg_o(upg[g]),
            .cnt_o(cnt[g]), .data_o(dat[g])
        );
    end

    mfb_lowpick #(.N(NUM_ENT)) u_free_pick (
        .vec_i(free_vec), .oh_o(free_oh), .idx_o(free_idx), .any_o(free_any)
    );
    mfb_lowpick #(.N(NUM_ENT)) u_full_pick (
        .vec_i(full_vec), .oh_o(full_oh), .idx_o(full_idx), .any_o(full_any)
    );
    mfb_age #(.N(NUM_ENT)) u_age (
        .clk(clk), .rst_n(rst_n), .alloc_oh_i(alloc_oh), .cand_i(pend_vec),
        .pick_oh_o(pend_pick_oh)
    );

    // request acceptance and routing
    always_comb begin
        match_any  = |match_vec;
        match_full = |(match_vec & full_vec);
        req_ready  = req_hit || (match_any ? !match_full : free_any);
        take       = req_valid && req_ready && !req_hit;
        alloc_oh   = (take && !match_any) ? free_oh : '0;
        merge_oh   = (take && match_any) ? match_vec : '0;
        issue_oh   = dn_ready ? pend_pick_oh : '0;
        drain_oh   = cw_ready ? full_oh : '0;
    end

    // one-hot selections onto the outgoing buses
    always_comb begin
        match_idx = '0;
        dn_idx    = '0;
        dn_line   = '0;
        dn_type   = '0;
        cw_line   = '0;
        cw_data   = '0;
        wake_type = '0;
        wake_upg  = 1'b0;
        beat_cnt  = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
            if (pend_pick_oh[i]) begin
                dn_idx  = dn_idx | IDX_W'(i);
                dn_line = dn_line | ln[i];
                dn_type = dn_type | ty[i];
            end
            if (full_oh[i]) begin
                cw_line   = cw_line | ln[i];
                cw_data   = cw_data | dat[i];
                wake_type = wake_type | ty[i];
                wake_upg  = wake_upg | upg[i];
            end
            if (beat_oh[i]) beat_cnt = beat_cnt | cnt[i];
        end
        dn_valid   = |pend_vec;
        cw_valid   = full_any;
        cw_idx     = full_idx;
        wake_valid = full_any && cw_ready;
        wake_idx   = full_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rid    <= '0;
            rsp_idx    <= '0;
            rsp_merged <= 1'b0;
            fwd_valid  <= 1'b0;
            fwd_idx    <= '0;
            fwd_beat   <= '0;
            fwd_data   <= '0;
        end else begin
            rsp_valid  <= take;
            rsp_rid    <= req_rid;
            rsp_idx    <= match_any ? match_idx : free_idx;
            rsp_merged <= match_any;
            fwd_valid  <= |beat_oh;
            fwd_idx    <= fill_idx;
            fwd_beat   <= beat_cnt;
            fwd_data   <= fill_data;
        end
    end

    AST_ONE_LINE_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot0(match_vec)); // R3
    AST_HIT_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hit) |=> !rsp_valid); // R1
    AST_FREE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> free_vec[$past(wake_idx)]); // R10
    AST_FWD_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> !fwd_valid); // R9
endmodule

// File: tb/sim_mfb_tracker.sv
`timescale 1ns/1ps
module sim_mfb_tracker;
    localparam int N = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic         req_valid = 0, req_hit = 0;
    logic [25:0]  req_line = '0;
    logic [1:0]   req_type = '0;
    logic [5:0]   req_rid = '0;
    logic         dn_ready = 0, fill_valid = 0, cw_ready = 0;
    logic [3:0]   fill_idx = '0;
    logic [127:0] fill_data = '0;

    logic         req_ready, rsp_valid, rsp_merged, dn_valid, fwd_valid, cw_valid;
    logic         wake_valid, wake_upg;
    logic [5:0]   rsp_rid;
    logic [3:0]   rsp_idx, dn_idx, fwd_idx, cw_idx, wake_idx;
    logic [25:0]  dn_line, cw_line;
    logic [1:0]   dn_type, fwd_beat, wake_type;
    logic [127:0] fwd_data;
    logic [511:0] cw_data;

    mfb_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_hit(req_hit), .req_line(req_line),
        .req_type(req_type), .req_rid(req_rid), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rid(rsp_rid), .rsp_idx(rsp_idx), .rsp_merged(rsp_merged),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_idx(dn_idx), .dn_line(dn_line),
        .dn_type(dn_type),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_data(fill_data),
        .fwd_valid(fwd_valid), .fwd_idx(fwd_idx), .fwd_beat(fwd_beat), .fwd_data(fwd_data),
        .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_idx(cw_idx), .cw_line(cw_line),
        .cw_data(cw_data),
        .wake_valid(wake_valid), .wake_idx(wake_idx), .wake_type(wake_type), .wake_upg(wake_upg)
    );

    int n_checks = 0;
    int n_fail = 0;

    // model of entries: 0 free, 1 pending, 2 issued, 3 full
    int           m_st  [N];
    logic [25:0]  m_ln  [N];
    int           m_ty  [N];
    bit           m_upg [N];
    int           m_cnt [N];
    logic [511:0] m_dat [N];
    longint       m_seq [N];
    longint       seqctr = 0;

    bit           e_rsp_v = 0, e_rsp_m = 0;
    int           e_rsp_idx = 0;
    logic [5:0]   e_rsp_rid = '0;
    string        e_rsp_tag = "R2";
    bit           e_fwd_v = 0;
    int           e_fwd_idx = 0, e_fwd_beat = 0;
    logic [127:0] e_fwd_data = '0;

    int x_match, x_free, x_pick, x_cw;
    bit x_ready;

    function automatic logic [127:0] beat_pat(logic [25:0] line, int k);
        return {4{line, 6'(k)}};
    endfunction

    function automatic logic [25:0] lname(int i);
        return 26'h1000 + 26'(i);
    endfunction

    task automatic chk(string tag, string what, logic [511:0] act, logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic eval();
        longint best;
        x_match = -1;
        x_free = -1;
        x_pick = -1;
        x_cw = -1;
        best = 0;
        for (int i = 0; i < N; i++)
            if (m_st[i] != 0 && m_ln[i] == req_line) x_match = i;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_st[i] == 0) x_free = i;
            if (m_st[i] == 3) x_cw = i;
        end
        for (int i = 0; i < N; i++)
            if (m_st[i] == 1 && (x_pick < 0 || m_seq[i] < best)) begin
                x_pick = i;
                best = m_seq[i];
            end
        x_ready = req_hit || (x_match >= 0 ? (m_st[x_match] != 3) : (x_free >= 0));
    endtask

    task automatic check_now();
        #0.5;
        eval();
        chk(req_hit ? "R1" : "R6", "req_ready", 512'(req_ready), 512'(x_ready));
        chk(e_rsp_tag, "rsp_valid", 512'(rsp_valid), 512'(e_rsp_v));
        if (e_rsp_v) begin
            chk(e_rsp_tag, "rsp_rid", 512'(rsp_rid), 512'(e_rsp_rid));
            chk(e_rsp_tag, "rsp_idx", 512'(rsp_idx), 512'(e_rsp_idx));
            chk(e_rsp_tag, "rsp_merged", 512'(rsp_merged), 512'(e_rsp_m));
        end
        chk("R7", "dn_valid", 512'(dn_valid), 512'(x_pick >= 0));
        if (x_pick >= 0) begin
            chk("R7", "dn_idx", 512'(dn_idx), 512'(x_pick));
            chk("R7", "dn_line", 512'(dn_line), 512'(m_ln[x_pick]));
            chk("R4", "dn_type", 512'(dn_type), 512'(m_ty[x_pick]));
        end
        chk("R10", "cw_valid", 512'(cw_valid), 512'(x_cw >= 0));
        chk("R10", "wake_valid", 512'(wake_valid), 512'(x_cw >= 0 && cw_ready));
        if (x_cw >= 0) begin
            chk("R10", "cw_idx", 512'(cw_idx), 512'(x_cw));
            chk("R10", "cw_line", 512'(cw_line), 512'(m_ln[x_cw]));
            chk("R8", "cw_data", cw_data, m_dat[x_cw]);
            if (cw_ready) begin
                chk("R10", "wake_idx", 512'(wake_idx), 512'(x_cw));
                chk("R5", "wake_type", 512'(wake_type), 512'(m_ty[x_cw]));
                chk("R5", "wake_upg", 512'(wake_upg), 512'(m_upg[x_cw]));
            end
        end
        chk("R9", "fwd_valid", 512'(fwd_valid), 512'(e_fwd_v));
        if (e_fwd_v) begin
            chk("R9", "fwd_idx", 512'(fwd_idx), 512'(e_fwd_idx));
            chk("R9", "fwd_beat", 512'(fwd_beat), 512'(e_fwd_beat));
            chk("R9", "fwd_data", 512'(fwd_data), 512'(e_fwd_data));
        end
    endtask

    task automatic tick();
        int  pre [N];
        int  issued;
        bit  take;
        @(posedge clk);
        for (int i = 0; i < N; i++) pre[i] = m_st[i];
        issued = -1;
        if (cw_ready && x_cw >= 0) m_st[x_cw] = 0;
        if (dn_ready && x_pick >= 0) begin
            m_st[x_pick] = 2;
            issued = x_pick;
        end
        e_fwd_v = 0;
        if (fill_valid && int'(fill_idx) < N && pre[fill_idx] == 2) begin
            m_dat[fill_idx][m_cnt[fill_idx]*128 +: 128] = fill_data;
            e_fwd_v = 1;
            e_fwd_idx = int'(fill_idx);
            e_fwd_beat = m_cnt[fill_idx];
            e_fwd_data = fill_data;
            m_cnt[fill_idx]++;
            if (m_cnt[fill_idx] == 4) m_st[fill_idx] = 3;
        end
        take = req_valid && x_ready && !req_hit;
        e_rsp_v = take;
        e_rsp_rid = req_rid;
        e_rsp_tag = (req_valid && req_hit) ? "R1" : "R2";
        if (take) begin
            if (x_match >= 0) begin
                if (int'(req_type) > m_ty[x_match]) begin
                    m_ty[x_match] = int'(req_type);
                    if (pre[x_match] == 2 || issued == x_match) m_upg[x_match] = 1;
                end
                e_rsp_idx = x_match;
                e_rsp_m = 1;
                e_rsp_tag = "R3";
            end else begin
                m_st[x_free] = 1;
                m_ln[x_free] = req_line;
                m_ty[x_free] = int'(req_type);
                m_upg[x_free] = 0;
                m_cnt[x_free] = 0;
                m_seq[x_free] = seqctr++;
                e_rsp_idx = x_free;
                e_rsp_m = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic drive(bit rv, bit hit, logic [25:0] line, int typ, int rid,
                         bit dr, bit fv, int fi, logic [127:0] fd, bit cr);
        req_valid = rv;
        req_hit = hit;
        req_line = line;
        req_type = 2'(typ);
        req_rid = 6'(rid);
        dn_ready = dr;
        fill_valid = fv;
        fill_idx = 4'(fi);
        fill_data = fd;
        cw_ready = cr;
    endtask

    task automatic step();
        check_now();
        tick();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int fi;
        bit fv;
        void'($urandom(32'h5eed_2024));
        for (int i = 0; i < N; i++) begin
            m_st[i] = 0; m_ln[i] = '0; m_ty[i] = 0; m_upg[i] = 0;
            m_cnt[i] = 0; m_dat[i] = '0; m_seq[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R11: reset state
        chk("R11", "rsp_valid", 512'(rsp_valid), 512'(0));
        chk("R11", "dn_valid", 512'(dn_valid), 512'(0));
        chk("R11", "cw_valid", 512'(cw_valid), 512'(0));
        chk("R11", "wake_valid", 512'(wake_valid), 512'(0));
        chk("R11", "fwd_valid", 512'(fwd_valid), 512'(0));
        @(negedge clk);

        // R2: fill all entries with distinct prefetches, nothing issued
        for (int i = 0; i < N; i++) begin
            drive(1, 0, lname(i), 0, i, 0, 0, 0, '0, 0);
            step();
        end
        // R1: hit to an untracked line
        drive(1, 1, 26'h2000, 1, 40, 0, 0, 0, '0, 0);
        step();
        // R6: new line with no free entry
        drive(1, 0, 26'h3000, 1, 41, 0, 0, 0, '0, 0);
        step();
        // R4: raise entry 3 to ownership before issue
        drive(1, 0, lname(3), 3, 42, 0, 0, 0, '0, 0);
        step();
        // R7: issue oldest (entry 0)
        drive(0, 0, '0, 0, 0, 1, 0, 0, '0, 0);
        step();
        // R5: raise entry 0 after its issue
        drive(1, 0, lname(0), 1, 43, 0, 0, 0, '0, 0);
        step();
        // R8: beat to a pending entry is ignored
        drive(0, 0, '0, 0, 0, 0, 1, 5, beat_pat(lname(5), 0), 0);
        step();
        // R8 R9: four beats to entry 0
        for (int k = 0; k < 4; k++) begin
            drive(0, 0, '0, 0, 0, 0, 1, 0, beat_pat(lname(0), k), 0);
            step();
        end
        // R6: merge into a full entry is refused
        drive(1, 0, lname(0), 3, 44, 0, 0, 0, '0, 0);
        step();
        // R10: drain entry 0 while a new line is refused in the same cycle
        drive(1, 0, 26'h3001, 2, 45, 0, 0, 0, '0, 1);
        step();
        // entry 0 is free again and is reused
        drive(1, 0, 26'h3001, 2, 46, 0, 0, 0, '0, 0);
        step();

        // constrained random traffic
        for (int c = 0; c < 30000; c++) begin
            fv = 0;
            fi = 0;
            begin
                int start = int'($urandom % N);
                for (int s = 0; s < N; s++) begin
                    int e = (start + s) % N;
                    if (!fv && m_st[e] == 2 && ($urandom % 100) < 70) begin
                        fv = 1;
                        fi = e;
                    end
                end
            end
            if (fv)
                drive(($urandom % 100) < 60, ($urandom % 100) < 15,
                      lname(int'($urandom % 14)), int'($urandom % 4), int'($urandom % 64),
                      ($urandom % 100) < 50, 1, fi, beat_pat(m_ln[fi], m_cnt[fi]),
                      ($urandom % 100) < 50);
            else
                drive(($urandom % 100) < 60, ($urandom % 100) < 15,
                      lname(int'($urandom % 14)), int'($urandom % 4), int'($urandom % 64),
                      ($urandom % 100) < 50, ($urandom % 100) < 5, int'($urandom % N),
                      {4{$urandom}}, ($urandom % 100) < 50);
            step();
        end
        finish_run();
    end
endmodule